// File: doc/BRIEF.md
# DDR SDRAM Command Legality Monitor

This block watches the command pins of a four-bank DDR SDRAM on every rising clock edge. The pins are chip select, row strobe, column strobe, write enable, the two bank-address bits and the A10 auto-precharge line. It decodes each cycle into a command and keeps a model of every bank as open or closed. It also counts, in clock cycles, how long ago each bank was activated or precharged and how long ago the last activate, column access, mode-register load and refresh took place.

When a command breaks a bank-state rule or a minimum spacing, the block reports it on the following cycle. It drives a one-cycle strobe together with a 4-bit code and also sets an error bit that stays set until a synchronous reset. Every minimum spacing is a parameter counted in clocks. The monitor is passive, so it is placed beside a memory controller in simulation or on silicon to catch protocol slips.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After synchronous reset (`rst` high at a rising edge) every bank is closed, `bank_open` is 0, `viol_valid` is 0, `viol_code` is 0 and `err_sticky` is 0.
- R2: The command is decoded from {cs_n, ras_n, cas_n, we_n}: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode load, 0110 burst stop, 0111 no-op. An activate sets `bank_open[ba]`, where bit index i stands for the bank-address value {BA1,BA0}=i. A precharge clears `bank_open[ba]`. A precharge with `a10` high clears all four bits and ignores `ba`.
- R3: A mode load while any bank is open gives code 3. A refresh while any bank is open gives code 4.
- R4: Any command other than no-op or deselect that comes fewer than T_MRD cycles after a mode load gives code 1. Such a command fewer than T_RFC cycles after a refresh gives code 2.
- R5: An activate to an open bank gives code 5. A read or write to a closed bank gives code 6.
- R6: A read or write with `a10` high to an open bank with no auto-precharge pending arms auto-precharge. The bank closes at the edge ending the cycle that lies L cycles after the column command, and that cycle counts as its precharge for the T_RP window. L is 1, 2 or 4 for `burst_sel` 0, 1 or 2/3. A read or write to that bank while the auto-precharge is pending gives code 7.
- R7: A read or write fewer than T_CCD cycles after the previous read or write gives code 8.
- R8: A read or write fewer than T_RCD cycles after its bank's activate gives code 9. A precharge that closes an open bank fewer than T_RAS cycles after that bank's activate gives code 10.
- R9: An activate gives code 11 if it comes fewer than T_RP cycles after its bank's last precharge, code 12 if fewer than T_RC cycles after its bank's last activate, and code 13 if fewer than T_RRD cycles after any activate.
- R10: When several rules break at once, the lowest code is reported. `viol_valid` pulses high in the cycle after the offending command with `viol_code` set to that code. `viol_code` is 0 whenever `viol_valid` is low.
- R11: `err_sticky` rises together with the first `viol_valid` and stays high until reset.
- R12: A cycle with `cs_n` high, or a no-op, raises no violation and changes no bank state, whatever the other pins carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address {BA1,BA0} |
| a10 | input | 1 | All-bank precharge / auto-precharge request |
| burst_sel | input | 2 | Burst length: 0=2, 1=4, 2 or 3=8 |
| bank_open | output | 4 | Open flag per bank |
| viol_valid | output | 1 | One-cycle violation strobe |
| viol_code | output | 4 | Code of the reported violation |
| err_sticky | output | 1 | Latched violation flag |

## Verification
The bench keeps every timing default (3, 3, 6, 2, 9, 10 and a 2-cycle mode-load gap) but sets T_CCD to 2. With the default of 1, two column commands can never be close enough to break the gap, so the tCCD code could never be reached. Short windows like these let random traffic that is mostly no-ops land on both sides of every window within a few cycles. The auto-precharge countdown is checked against a timestamp model for all three burst lengths, including collisions where an activate or column command falls on the very cycle the bank closes.

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6,
  parameter int T_RRD = 2,
  parameter int T_RC  = 9,
  parameter int T_RFC = 10,
  parameter int T_MRD = 2,
  parameter int T_CCD = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  input  logic       a10,
  input  logic [1:0] burst_sel,
  output logic [3:0] bank_open,
  output logic       viol_valid,
  output logic [3:0] viol_code,
  output logic       err_sticky
);
  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_MAX = maxi(maxi(maxi(T_RCD, T_RP), maxi(T_RAS, T_RRD)),
                              maxi(maxi(T_RC, T_RFC), maxi(T_MRD, T_CCD)));
  localparam int CW = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] SAT   = CW'(T_MAX);
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] L_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC);
  localparam logic [CW-1:0] L_RFC = CW'(T_RFC);
  localparam logic [CW-1:0] L_MRD = CW'(T_MRD);
  localparam logic [CW-1:0] L_CCD = CW'(T_CCD);

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == SAT) ? v : v + 1'b1;
  endfunction

  wire sel_n   = cs_n;
  wire is_act  = !sel_n && !ras_n &&  cas_n &&  we_n;
  wire is_rd   = !sel_n &&  ras_n && !cas_n &&  we_n;
  wire is_wr   = !sel_n &&  ras_n && !cas_n && !we_n;
  wire is_pre  = !sel_n && !ras_n &&  cas_n && !we_n;
  wire is_ref  = !sel_n && !ras_n && !cas_n &&  we_n;
  wire is_mrs  = !sel_n && !ras_n && !cas_n && !we_n;
  wire any_cmd = !sel_n && !(ras_n && cas_n && we_n);
  wire is_col  = is_rd || is_wr;

  wire [2:0] ap_len = (burst_sel == 2'd0) ? 3'd1 : (burst_sel == 2'd1) ? 3'd2 : 3'd4;

  logic [CW-1:0] act_age [4];
  logic [CW-1:0] pre_age [4];
  logic [2:0]    ap_cnt  [4];
  logic [CW-1:0] any_act_age, col_age, mrd_age, rfc_age;
  logic [3:0]    ras_hit;
  logic [3:0]    code_n;
  logic          pre_ras;

  always_comb begin
    for (int i = 0; i < 4; i++) ras_hit[i] = bank_open[i] && (act_age[i] < L_RAS);
    pre_ras = is_pre && (a10 ? |ras_hit : ras_hit[ba]);
  end

  always_comb begin
    code_n = 4'd0;
    if      (any_cmd && mrd_age < L_MRD)              code_n = 4'd1;
    else if (any_cmd && rfc_age < L_RFC)              code_n = 4'd2;
    else if (is_mrs && |bank_open)                    code_n = 4'd3;
    else if (is_ref && |bank_open)                    code_n = 4'd4;
    else if (is_act && bank_open[ba])                 code_n = 4'd5;
    else if (is_col && !bank_open[ba])                code_n = 4'd6;
    else if (is_col && ap_cnt[ba] != 3'd0)            code_n = 4'd7;
    else if (is_col && col_age < L_CCD)               code_n = 4'd8;
    else if (is_col && act_age[ba] < L_RCD)           code_n = 4'd9;
    else if (pre_ras)                                 code_n = 4'd10;
    else if (is_act && pre_age[ba] < L_RP)            code_n = 4'd11;
    else if (is_act && act_age[ba] < L_RC)            code_n = 4'd12;
    else if (is_act && any_act_age < L_RRD)           code_n = 4'd13;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        bank_open[i] <= 1'b0;
        act_age[i]   <= SAT;
        pre_age[i]   <= SAT;
        ap_cnt[i]    <= 3'd0;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        act_age[i] <= bump(act_age[i]);
        pre_age[i] <= bump(pre_age[i]);
        if (ap_cnt[i] != 3'd0) begin
          ap_cnt[i] <= ap_cnt[i] - 3'd1;
          if (ap_cnt[i] == 3'd1) begin
            bank_open[i] <= 1'b0;
            pre_age[i]   <= CW'(1);
          end
        end
        if (is_act && ba == 2'(i)) begin
          bank_open[i] <= 1'b1;
          act_age[i]   <= CW'(1);
          ap_cnt[i]    <= 3'd0;
        end
        if (is_pre && (a10 || ba == 2'(i))) begin
          bank_open[i] <= 1'b0;
          pre_age[i]   <= CW'(1);
          ap_cnt[i]    <= 3'd0;
        end
        if (is_col && a10 && ba == 2'(i) && bank_open[i] && ap_cnt[i] == 3'd0)
          ap_cnt[i] <= ap_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_act_age <= SAT;
      col_age     <= SAT;
      mrd_age     <= SAT;
      rfc_age     <= SAT;
      viol_valid  <= 1'b0;
      viol_code   <= 4'd0;
      err_sticky  <= 1'b0;
    end else begin
      any_act_age <= is_act ? CW'(1) : bump(any_act_age);
      col_age     <= is_col ? CW'(1) : bump(col_age);
      mrd_age     <= is_mrs ? CW'(1) : bump(mrd_age);
      rfc_age     <= is_ref ? CW'(1) : bump(rfc_age);
      viol_valid  <= code_n != 4'd0;
      viol_code   <= code_n;
      err_sticky  <= err_sticky || (code_n != 4'd0);
    end
  end

  p_code_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> viol_code != 4'd0);
  p_code_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !viol_valid |-> viol_code == 4'd0);
  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);
  p_err_with_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> err_sticky);
  p_deselect_silent_r12: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !viol_valid);
  p_pre_all_closes_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && cas_n && !we_n && a10) |=> bank_open == 4'b0000);
  p_act_opens_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && cas_n && we_n) |=> bank_open[$past(ba)]);
endmodule

// File: tb/test_sdram_cmd_checker.sv
module test_sdram_cmd_checker;
  localparam int P_RCD = 3, P_RP = 3, P_RAS = 6, P_RRD = 2;
  localparam int P_RC = 9, P_RFC = 10, P_MRD = 2, P_CCD = 2;
  localparam int NEVER = -1000;

  logic clk = 0, rst = 1;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [1:0] ba = 0, burst_sel = 0;
  logic [3:0] bank_open, viol_code;
  logic viol_valid, err_sticky;

  sdram_cmd_checker #(.T_RCD(P_RCD), .T_RP(P_RP), .T_RAS(P_RAS), .T_RRD(P_RRD),
    .T_RC(P_RC), .T_RFC(P_RFC), .T_MRD(P_MRD), .T_CCD(P_CCD)) i_sdram_cmd_checker (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .burst_sel(burst_sel), .bank_open(bank_open),
    .viol_valid(viol_valid), .viol_code(viol_code), .err_sticky(err_sticky));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, last_code = 0;
  bit done = 0;
  bit m_open [4];
  int t_act [4], t_pre [4], ap_end [4];
  int t_any_act, t_col, t_mrs, t_ref;
  bit m_err;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int code);
    case (code)
      1, 2:       return "R4";
      3, 4:       return "R3";
      5, 6:       return "R5";
      7:          return "R6";
      8:          return "R7";
      9, 10:      return "R8";
      11, 12, 13: return "R9";
      default:    return "R10";
    endcase
  endfunction

  function automatic int half_of(logic [1:0] bs);
    return (bs == 2'd0) ? 1 : (bs == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit any_open();
    return m_open[0] | m_open[1] | m_open[2] | m_open[3];
  endfunction

  function automatic logic [3:0] open_vec();
    return {m_open[3], m_open[2], m_open[1], m_open[0]};
  endfunction

  function automatic int expect_code(bit cs, bit ras, bit cas, bit we, int b, bit a, int c);
    bit act = !cs && !ras && cas && we;
    bit col = !cs && ras && !cas;
    bit pre = !cs && !ras && cas && !we;
    bit rf  = !cs && !ras && !cas && we;
    bit mr  = !cs && !ras && !cas && !we;
    bit anyc = !cs && !(ras && cas && we);
    bit ras_bad = 0;
    for (int i = 0; i < 4; i++)
      if ((a || i == b) && m_open[i] && c - t_act[i] < P_RAS) ras_bad = 1;
    if (anyc && c - t_mrs < P_MRD) return 1;
    if (anyc && c - t_ref < P_RFC) return 2;
    if (mr && any_open()) return 3;
    if (rf && any_open()) return 4;
    if (act && m_open[b]) return 5;
    if (col && !m_open[b]) return 6;
    if (col && ap_end[b] != 0) return 7;
    if (col && c - t_col < P_CCD) return 8;
    if (col && c - t_act[b] < P_RCD) return 9;
    if (pre && ras_bad) return 10;
    if (act && c - t_pre[b] < P_RP) return 11;
    if (act && c - t_act[b] < P_RC) return 12;
    if (act && c - t_any_act < P_RRD) return 13;
    return 0;
  endfunction

  task automatic model_update(bit cs, bit ras, bit cas, bit we, int b, bit a, logic [1:0] bs, int c);
    bit act = !cs && !ras && cas && we;
    bit col = !cs && ras && !cas;
    bit pre = !cs && !ras && cas && !we;
    bit arm = col && a && m_open[b] && ap_end[b] == 0;
    for (int i = 0; i < 4; i++)
      if (ap_end[i] != 0 && ap_end[i] == c) begin
        m_open[i] = 0; t_pre[i] = c; ap_end[i] = 0;
      end
    if (act) begin
      m_open[b] = 1; t_act[b] = c; ap_end[b] = 0; t_any_act = c;
    end
    if (pre)
      for (int i = 0; i < 4; i++)
        if (a || i == b) begin m_open[i] = 0; t_pre[i] = c; ap_end[i] = 0; end
    if (arm) ap_end[b] = c + half_of(bs);
    if (col) t_col = c;
    if (!cs && !ras && !cas && !we) t_mrs = c;
    if (!cs && !ras && !cas && we) t_ref = c;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; t_act[i] = NEVER; t_pre[i] = NEVER; ap_end[i] = 0;
    end
    t_any_act = NEVER; t_col = NEVER; t_mrs = NEVER; t_ref = NEVER;
    m_err = 0; cyc = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cs_n = 1;
    repeat (2) @(negedge clk);
    chk(bank_open == 4'b0 && !viol_valid && viol_code == 0 && !err_sticky, "R1",
        {bank_open, viol_code, viol_valid, err_sticky}, 0);
    rst = 0;
    model_reset();
  endtask

  task automatic step(bit cs, bit ras, bit cas, bit we, logic [1:0] b, bit a, logic [1:0] bs);
    int e;
    @(negedge clk);
    cs_n = cs; ras_n = ras; cas_n = cas; we_n = we; ba = b; a10 = a; burst_sel = bs;
    e = expect_code(cs, ras, cas, we, int'(b), a, cyc);
    model_update(cs, ras, cas, we, int'(b), a, bs, cyc);
    if (e != 0) m_err = 1;
    @(posedge clk);
    #1;
    last_code = int'(viol_code);
    chk(viol_valid == (e != 0) && int'(viol_code) == e, tag_of(e), int'(viol_code), e);
    chk(bank_open == open_vec(), "R2", int'(bank_open), int'(open_vec()));
    chk(err_sticky == m_err, "R11", int'(err_sticky), int'(m_err));
    cyc++;
  endtask

  task automatic nop();                       step(0, 1, 1, 1, 0, 0, 0); endtask
  task automatic act(logic [1:0] b);          step(0, 0, 1, 1, b, 0, 0); endtask
  task automatic rd(logic [1:0] b, bit a, logic [1:0] bs); step(0, 1, 0, 1, b, a, bs); endtask
  task automatic pre(logic [1:0] b, bit a);   step(0, 0, 1, 0, b, a, 0); endtask
  task automatic refr();                      step(0, 0, 0, 1, 0, 0, 0); endtask
  task automatic mrs();                       step(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    act(2'd1); nop();
    rd(2'd1, 0, 0);  chk(last_code == 9, "R8", last_code, 9);
    nop();
    act(2'd1);       chk(last_code == 5, "R5", last_code, 5);
    pre(2'd1, 0);    chk(last_code == 10, "R8", last_code, 10);
    act(2'd1);       chk(last_code == 11, "R9", last_code, 11);
    rd(2'd3, 0, 0);  chk(last_code == 6, "R5", last_code, 6);

    do_reset();
    act(2'd2); nop(); nop(); nop();
    rd(2'd2, 1, 2'd1);  chk(last_code == 0, "R6", last_code, 0);
    rd(2'd2, 0, 2'd1);  chk(last_code == 7, "R6", last_code, 7);
    chk(bank_open[2] == 1, "R6", int'(bank_open[2]), 1);
    nop();              chk(bank_open[2] == 0, "R6", int'(bank_open[2]), 0);
    act(2'd2);          chk(last_code == 11, "R9", last_code, 11);
    act(2'd0);          chk(last_code == 13, "R9", last_code, 13);
    pre(2'd3, 1);       chk(bank_open == 4'b0, "R2", int'(bank_open), 0);

    do_reset();
    act(2'd3);
    refr();          chk(last_code == 4, "R3", last_code, 4);
    mrs();           chk(last_code == 2, "R4", last_code, 2);
    do_reset();
    mrs();           chk(last_code == 0, "R3", last_code, 0);
    act(2'd0);       chk(last_code == 1, "R4", last_code, 1);
    step(1, 0, 0, 0, 2'd0, 1, 0);
    chk(last_code == 0 && bank_open == 4'b0001, "R12", int'(bank_open), 1);
    nop(); nop();
    rd(2'd0, 0, 0);
    rd(2'd0, 0, 0);  chk(last_code == 8, "R7", last_code, 8);
    repeat (3) nop();
    chk(err_sticky == 1, "R11", int'(err_sticky), 1);
    do_reset();
    act(2'd0); act(2'd2); chk(last_code == 13, "R9", last_code, 13);

    for (int n = 0; n < 6000; n++) begin
      int k = $urandom_range(0, 99);
      logic [1:0] b = 2'($urandom_range(0, 3));
      bit a = ($urandom_range(0, 9) < 3);
      logic [1:0] bs = 2'($urandom_range(0, 3));
      if (k < 45)      nop();
      else if (k < 50) step(1, 1'($urandom), 1'($urandom), 1'($urandom), b, a, bs);
      else if (k < 65) act(b);
      else if (k < 75) rd(b, a, bs);
      else if (k < 83) step(0, 1, 0, 0, b, a, bs);
      else if (k < 92) pre(b, a);
      else if (k < 95) refr();
      else if (k < 97) mrs();
      else             step(0, 1, 1, 0, b, a, bs);
      if (n % 1500 == 1499) do_reset();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule